// File: doc/BRIEF.md
# Descriptor-Chained Transmit Frame DMA

This block is the transmit half of a frame DMA. It walks a ring of descriptors kept in system memory and turns each frame buffer into a stream of 32-bit words for a downstream MAC. Every frame uses a pair of descriptors. The first pair member reads the buffer. The buffer's first halfword is the frame's byte count, and the frame bytes follow it directly. The second pair member writes one completion word back to memory, so software can see which frames have gone out.

Software places descriptors in memory and loads the address of the first descriptor. It then starts the engine with an enable write. The engine follows each descriptor's link pointer until it fetches a descriptor whose enable bit is clear. There it stops and drops `busy`. Software can therefore keep appending pairs behind a parked descriptor and restart the engine later. A one-cycle `irq_done` pulse marks each completed descriptor that asks for it.

The memory port is a plain request port. A read issued in one cycle returns `mem_rdata` in the next cycle, and a write completes in the cycle it is issued. The frame stream is valid/ready. Once `tx_valid` is high, it stays high, and `tx_data` and `tx_last` stay unchanged, until a cycle in which `tx_ready` is also high. The engine fetches no further buffer word while a word waits, so back-pressure holds the engine in place and loses nothing.

Top module: `ndma_tx_engine`

## Requirements
- R1: After reset `busy`, `tx_valid`, `irq_done`, `mem_rd` and `mem_wr` are all low.
- R2: A control write with `ctl_sel`=1 and bit 0 of `ctl_wdata` set, made while idle, starts the engine at the loaded descriptor pointer, and `busy` is high in the cycle after that write. The same write with bit 0 clear does not start it.
- R3: While `busy` is high, control writes are ignored. A pointer write (`ctl_sel`=0) does not change the pointer used by the next start, and a start write does not begin a second walk.
- R4: A descriptor is three 32-bit words at byte offsets +0 (next-descriptor pointer), +4 (buffer address) and +8. The low halfword at +8 is the config word, with bit 0 = enable, bit 1 = direction (0 reads a frame, 1 writes status) and bit 4 = interrupt enable. The engine ignores the other config bits and the high halfword.
- R5: A read descriptor streams exactly ceil((L+2)/4) words, taken from consecutive word addresses starting at its buffer address. L is bits 15:0 of the first buffer word, and that first word is itself the first streamed word.
- R6: `tx_last` is high on the final word of a frame and low on every other word.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R8: A write descriptor stores the word {bit 31 = 1, bits 15:0 = L of the most recent frame, other bits 0} at its buffer address.
- R9: After each descriptor the engine continues at that descriptor's next pointer, so a link from the last pair back to the first pair is followed around the ring.
- R10: Fetching a descriptor with enable clear stops the engine. `busy` falls, and no word is streamed or written for that descriptor.
- R11: `irq_done` pulses for one cycle, in the cycle after a descriptor with interrupt enable set completes (on the last frame-word handshake or on the status write). A disabled descriptor raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_sel | input | 1 | 0: descriptor pointer, 1: start (bit 0 = enable) |
| ctl_wdata | input | 32 | Control write data |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| tx_data | output | 32 | Stream word |
| tx_valid | output | 1 | Stream word valid |
| tx_ready | input | 1 | Downstream accepts the word |
| tx_last | output | 1 | Final word of a frame |
| busy | output | 1 | Engine is walking the chain |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
Timing is counted from the rising edge that takes a start write. `busy` is high after that edge. The descriptor fetch takes four cycles, so the first frame word appears six edges later. Each later word appears three edges after the previous handshake. A status write commits on the fifth edge after the previous descriptor completes, and `irq_done` is high in the cycle after the completion edge. The bench samples outputs on falling edges. It compares stream words only at observed handshakes, in scoreboard order, rather than at fixed timestamps, and it checks status words and interrupt counts only after `busy` has fallen. This keeps the checks valid both under back-pressure and with `tx_ready` held high.

// File: rtl/ndma_pkg.sv
package ndma_pkg;
  localparam int DATA_W          = 32;
  localparam int CFG_EN_BIT      = 0;
  localparam int CFG_DIR_BIT     = 1;
  localparam int CFG_IE_BIT      = 4;
  localparam int CFG_W           = 16;
  localparam int DESC_NEXT_OFS   = 0;
  localparam int DESC_BUF_OFS    = 4;
  localparam int DESC_CFG_OFS    = 8;
  localparam int WORD_BYTES      = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_NEXT,
    ST_F_BUF,
    ST_F_CFG,
    ST_DECODE,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_SEND,
    ST_WR_STAT
  } seq_state_e;
endpackage

// File: rtl/ndma_ctrl_regs.sv
module ndma_ctrl_regs
  import ndma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              busy,
  output logic [AW-1:0]     ptr_q,
  output logic              start_pulse
);

  // pointer register only moves while the engine is parked
  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ctl_wr && !ctl_sel && !busy)
      ptr_q <= ctl_wdata[AW-1:0];
  end

  assign start_pulse = ctl_wr && ctl_sel && ctl_wdata[CFG_EN_BIT] && !busy;

  p_ptr_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(ptr_q));

  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy);

endmodule

// File: rtl/ndma_beat_counter.sv
module ndma_beat_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             adv,
  output logic             last_beat
);
  localparam int CNT_W = LEN_W;

  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] beat_q;
  logic             loaded_q;
  logic [LEN_W:0]   padded;
  logic [CNT_W-1:0] total_words;

  // two prefix bytes plus rounding up to whole 32-bit words
  assign padded      = {1'b0, len_in} + (LEN_W+1)'(5);
  assign total_words = CNT_W'(padded[LEN_W:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q  <= '0;
      beat_q   <= '0;
      loaded_q <= 1'b0;
    end else if (load) begin
      total_q  <= total_words;
      beat_q   <= '0;
      loaded_q <= 1'b1;
    end else if (adv) begin
      beat_q   <= beat_q + CNT_W'(1);
    end
  end

  assign last_beat = loaded_q && (beat_q == total_q - CNT_W'(1));

  p_beat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (beat_q < total_q));

  p_no_adv_past_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !last_beat);

endmodule

// File: rtl/ndma_sequencer.sv
module ndma_sequencer
  import ndma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic [AW-1:0]     ptr_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              busy,
  output logic              irq_done,
  output logic              cnt_load,
  output logic [LEN_W-1:0]  cnt_len,
  output logic              cnt_adv,
  input  logic              last_beat
);
  localparam int PAD_W = DATA_W - 1 - LEN_W;

  seq_state_e        state_q;
  logic [AW-1:0]     desc_q;
  logic [AW-1:0]     next_q;
  logic [AW-1:0]     buf_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] word_q;
  logic [LEN_W-1:0]  len_q;
  logic              first_q;
  logic              irq_q;
  logic              hs;
  logic              complete;

  assign hs       = tx_valid && tx_ready;
  assign complete = (state_q == ST_SEND && hs && last_beat) || (state_q == ST_WR_STAT);

  assign tx_valid = (state_q == ST_SEND);
  assign tx_data  = word_q;
  assign tx_last  = tx_valid && last_beat;
  assign busy     = (state_q != ST_IDLE);
  assign irq_done = irq_q;

  assign cnt_load = (state_q == ST_RD_CAP) && first_q;
  assign cnt_len  = mem_rdata[LEN_W-1:0];
  assign cnt_adv  = (state_q == ST_SEND) && hs && !last_beat;

  assign mem_wdata = {1'b1, {PAD_W{1'b0}}, len_q};

  always_comb begin
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    mem_addr = desc_q;
    unique case (state_q)
      ST_F_NEXT:  begin mem_rd = 1'b1; mem_addr = desc_q + AW'(DESC_NEXT_OFS); end
      ST_F_BUF:   begin mem_rd = 1'b1; mem_addr = desc_q + AW'(DESC_BUF_OFS);  end
      ST_F_CFG:   begin mem_rd = 1'b1; mem_addr = desc_q + AW'(DESC_CFG_OFS);  end
      ST_RD_REQ:  begin mem_rd = 1'b1; mem_addr = buf_q; end
      ST_WR_STAT: begin mem_wr = 1'b1; mem_addr = buf_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      cfg_q   <= '0;
      word_q  <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= complete && cfg_q[CFG_IE_BIT];
      unique case (state_q)
        ST_IDLE: if (start_pulse) begin
          desc_q  <= ptr_in;
          state_q <= ST_F_NEXT;
        end
        ST_F_NEXT: state_q <= ST_F_BUF;
        ST_F_BUF: begin
          next_q  <= mem_rdata[AW-1:0];
          state_q <= ST_F_CFG;
        end
        ST_F_CFG: begin
          buf_q   <= mem_rdata[AW-1:0];
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          cfg_q <= mem_rdata[CFG_W-1:0];
          if (!mem_rdata[CFG_EN_BIT])
            state_q <= ST_IDLE;
          else if (mem_rdata[CFG_DIR_BIT])
            state_q <= ST_WR_STAT;
          else begin
            first_q <= 1'b1;
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: state_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          word_q <= mem_rdata;
          if (first_q) begin
            len_q   <= mem_rdata[LEN_W-1:0];
            first_q <= 1'b0;
          end
          state_q <= ST_SEND;
        end
        ST_SEND: if (hs) begin
          if (last_beat) begin
            desc_q  <= next_q;
            state_q <= ST_F_NEXT;
          end else begin
            buf_q   <= buf_q + AW'(WORD_BYTES);
            state_q <= ST_RD_REQ;
          end
        end
        ST_WR_STAT: begin
          desc_q  <= next_q;
          state_q <= ST_F_NEXT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_stream_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  p_gap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

endmodule

// File: rtl/ndma_tx_engine.sv
module ndma_tx_engine
  import ndma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              busy,
  output logic              irq_done
);

  logic [AW-1:0]    ptr_q;
  logic             start_pulse;
  logic             cnt_load;
  logic [LEN_W-1:0] cnt_len;
  logic             cnt_adv;
  logic             last_beat;

  ndma_ctrl_regs #(.AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_sel     (ctl_sel),
    .ctl_wdata   (ctl_wdata),
    .busy        (busy),
    .ptr_q       (ptr_q),
    .start_pulse (start_pulse)
  );

  ndma_beat_counter #(.LEN_W(LEN_W)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load),
    .len_in    (cnt_len),
    .adv       (cnt_adv),
    .last_beat (last_beat)
  );

  ndma_sequencer #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .ptr_in      (ptr_q),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_last     (tx_last),
    .busy        (busy),
    .irq_done    (irq_done),
    .cnt_load    (cnt_load),
    .cnt_len     (cnt_len),
    .cnt_adv     (cnt_adv),
    .last_beat   (last_beat)
  );

endmodule

// File: tb/ndma_tx_engine_tb.sv
module ndma_tx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic        ctl_sel = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] tx_data;
  logic        tx_valid, tx_last, busy, irq_done;
  logic        tx_ready = 1'b1;

  always #5 clk = ~clk;

  ndma_tx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .busy(busy), .irq_done(irq_done)
  );

  // memory model with a host write port for the bench
  logic [31:0] mem [0:1023];
  logic        host_we = 1'b0;
  logic [31:0] host_addr = '0;
  logic [31:0] host_data = '0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
    else if (host_we) mem[host_addr[11:2]] <= host_data;
  end

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  int cyc     = 0;
  bit throttle = 1'b0;
  bit finished = 1'b0;
  logic [32:0] exp_q[$];

  localparam int P1A = 32'h100, P1B = 32'h10C, P2A = 32'h118, P2B = 32'h124;
  localparam int P3A = 32'h130, P3B = 32'h13C;
  localparam int B1 = 32'h400, B2 = 32'h500, B3 = 32'h600;
  localparam int S1 = 32'h800, S2 = 32'h804, S3 = 32'h808;
  localparam int L1 = 2, L2 = 3, L3 = 17;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgw(input bit en, input bit dir, input bit ie);
    return 16'(int'(en) | (int'(dir) << 1) | (2 << 2) | (int'(ie) << 4) | (6 << 8) | (7 << 12));
  endfunction

  task automatic host_wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = 32'(a); host_data = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic put_desc(input int a, input int nxt, input int bufa, input logic [15:0] cfg);
    host_wr(a,     32'(nxt));
    host_wr(a + 4, 32'(bufa));
    host_wr(a + 8, {16'h0001, cfg});
  endtask

  task automatic put_frame(input int base, input int len);
    int words;
    words = (len + 5) / 4;
    host_wr(base, {8'(base >> 8), 8'hC3, 16'(len)});
    for (int k = 1; k < words; k++)
      host_wr(base + 4 * k, 32'h5A00_0000 ^ (32'(base) << 8) ^ (32'(k) * 32'h0101_0111));
  endtask

  // driver side of the scoreboard: expected words taken from the bench's memory image
  task automatic expect_frame(input int base);
    int len, words;
    len   = int'(mem[base >> 2][15:0]);
    words = (len + 5) / 4;
    for (int k = 0; k < words; k++)
      exp_q.push_back({(k == words - 1), mem[(base >> 2) + k]});
  endtask

  task automatic ctl(input bit sel, input logic [31:0] d);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  // ready generator
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    tx_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor side of the scoreboard
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data  = '0;
  logic        prev_last  = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(tx_valid, "R7", "valid held under stall", 32'(tx_valid), 32'd1);
        check(tx_data == prev_data && tx_last == prev_last, "R7", "word held under stall",
              tx_data, prev_data);
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R10", "unexpected stream word", tx_data, 32'h0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          check(tx_data == e[31:0], "R5", "stream data", tx_data, e[31:0]);
          check(tx_last == e[32], "R6", "last marker", 32'(tx_last), 32'(e[32]));
        end
      end
      if (irq_done) irq_cnt++;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !tx_valid && !irq_done, "R1", "outputs after reset",
          {29'd0, busy, tx_valid, irq_done}, 32'd0);
    check(!mem_rd && !mem_wr, "R1", "memory idle after reset", {30'd0, mem_rd, mem_wr}, 32'd0);

    // build ring of three pairs; third pair's read descriptor parked (R4 layout)
    put_frame(B1, L1); put_frame(B2, L2); put_frame(B3, L3);
    put_desc(P1A, P1B, B1, cfgw(1, 0, 0));
    put_desc(P1B, P2A, S1, cfgw(1, 1, 1));
    put_desc(P2A, P2B, B2, cfgw(1, 0, 1));
    put_desc(P2B, P3A, S2, cfgw(1, 1, 1));
    put_desc(P3A, P3B, B3, cfgw(0, 0, 0));
    put_desc(P3B, P1A, S3, cfgw(1, 1, 1));

    // R2: start with enable clear does nothing
    ctl(1'b0, 32'(P1A));
    ctl(1'b1, 32'h0);
    @(negedge clk);
    check(!busy, "R2", "no start without enable bit", 32'(busy), 32'd0);

    // Phase A: run p1, p2, park on p3A
    irq_cnt = 0;
    expect_frame(B1); expect_frame(B2);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_sel = 1'b1; ctl_wdata = 32'h1;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    @(negedge clk);
    check(busy, "R2", "busy after start write", 32'(busy), 32'd1);
    // R3: writes while running are ignored
    ctl(1'b0, 32'(P2A));
    ctl(1'b1, 32'h1);
    wait_idle();
    check(exp_q.size() == 0, "R9", "phase A frames all seen", 32'(exp_q.size()), 32'd0);
    check(!busy, "R10", "stopped at disabled descriptor", 32'(busy), 32'd0);
    check(mem[S1 >> 2] == (32'h8000_0000 | L1), "R8", "status p1", mem[S1 >> 2], 32'h8000_0000 | L1);
    check(mem[S2 >> 2] == (32'h8000_0000 | L2), "R8", "status p2", mem[S2 >> 2], 32'h8000_0000 | L2);
    check(mem[S3 >> 2] == 32'h0, "R10", "no status for parked pair", mem[S3 >> 2], 32'h0);
    check(irq_cnt == 3, "R11", "phase A interrupts", 32'(irq_cnt), 32'd3);
    repeat (20) @(negedge clk);
    check(!busy && exp_q.size() == 0, "R3", "second start while busy ignored", 32'(busy), 32'd0);

    // Phase B: start only; pointer must still be p1A (R3)
    host_wr(S1, 32'h0); host_wr(S2, 32'h0);
    irq_cnt = 0;
    expect_frame(B1); expect_frame(B2);
    ctl(1'b1, 32'h1);
    wait_idle();
    check(exp_q.size() == 0, "R3", "restart used original pointer", 32'(exp_q.size()), 32'd0);
    check(mem[S1 >> 2] == (32'h8000_0000 | L1), "R3", "p1 rerun status", mem[S1 >> 2], 32'h8000_0000 | L1);
    check(irq_cnt == 3, "R11", "phase B interrupts", 32'(irq_cnt), 32'd3);

    // Phase C: wrap around the ring under back-pressure
    host_wr(S1, 32'h0); host_wr(S2, 32'h0);
    put_desc(P3A, P3B, B3, cfgw(1, 0, 0));
    put_desc(P2A, P2B, B2, cfgw(0, 0, 1));
    irq_cnt = 0;
    throttle = 1'b1;
    expect_frame(B3); expect_frame(B1);
    ctl(1'b0, 32'(P3A));
    ctl(1'b1, 32'h1);
    wait_idle();
    throttle = 1'b0;
    check(exp_q.size() == 0, "R9", "ring wrap frames seen", 32'(exp_q.size()), 32'd0);
    check(mem[S3 >> 2] == (32'h8000_0000 | L3), "R8", "status p3", mem[S3 >> 2], 32'h8000_0000 | L3);
    check(mem[S1 >> 2] == (32'h8000_0000 | L1), "R9", "status p1 after wrap", mem[S1 >> 2], 32'h8000_0000 | L1);
    check(mem[S2 >> 2] == 32'h0, "R10", "disabled p2 untouched", mem[S2 >> 2], 32'h0);
    check(irq_cnt == 2, "R11", "no irq from disabled descriptor", 32'(irq_cnt), 32'd2);
    repeat (10) @(negedge clk);
    check(!mem_rd && !mem_wr && !tx_valid, "R10", "quiet when parked",
          {29'd0, mem_rd, mem_wr, tx_valid}, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule